// File: doc/BRIEF.md
# Offset-Cancelling DAC Code Loop

This block produces the 12-bit code that drives one channel's offset-cancelling DAC. The code comes from one of two sources. The first is a static value supplied by configuration. The second is a slow digital integrator. The integrator sums the channel's raw 1-bit modulator output, counting a one as +1 and a zero as -1. Because of this, a residual DC level that pushes the modulator density away from one half steadily moves the DAC code until the offset is cancelled.

The integrator is an accumulator that holds 12 + K_MAX bits. Its top 12 bits are the DAC code. A time-constant field k gives the number of fractional bits below the code. Each bit moves the accumulator by 2^(K_MAX-k) LSBs. With k = 0, one bit moves the code by one step. With k = 15, 32768 net bits are needed for one code step. This brings second-scale time constants within reach at modulator rates.

The accumulator follows the configured value for as long as the register source is selected. A change to the integrator source therefore starts from the value the DAC already shows. The same code is routed to the DAC and into the channel's output packet.

Top module: `offset_trim_loop`

## Requirements
- R1: During and after reset the accumulator is at midscale, so with the integrator source selected the code reads 12'h800 until the first accepted bit.
- R2: When `useInteg` is 0, `dacCode` equals `regCode` in the same cycle, whatever the bitstream, `enable` or `tcSel` inputs do.
- R3: While the register source is selected, the accumulator loads `regCode` (placed in its top 12 bits, fraction cleared) on every clock. In the first cycle with `useInteg` at 1, `dacCode` equals the `regCode` value sampled at the previous clock edge.
- R4: With the integrator selected and `enable` and `bitValid` high at a clock edge, a 1 on `bitIn` adds 2^(15-k) to the 27-bit accumulator and a 0 subtracts it (k = `tcSel`). `dacCode` shows the accumulator's top 12 bits from the next cycle.
- R5: A clock edge with `bitValid` low leaves the accumulator and `dacCode` unchanged.
- R6: A clock edge with `enable` low leaves the accumulator and `dacCode` unchanged, even with valid bits present.
- R7: Further ones at full scale hold the code at 12'hFFF and never wrap.
- R8: Further zeros at zero hold the code at 12'h000 and never wrap.
- R9: With k = 0, each accepted bit moves the code by exactly one. With k = 15, a start at 12'h800 with zero fraction still reads 12'h800 after 32767 ones and reads 12'h801 after the 32768th.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | Strobe marking a new modulator bit |
| bitIn | input | 1 | Modulator output bit |
| useInteg | input | 1 | Source select: 1 = integrator, 0 = configured value |
| regCode | input | 12 | Configured static DAC code |
| tcSel | input | 4 | Time-constant field k, fractional bits below the code |
| enable | input | 1 | Integration enable |
| dacCode | output | 12 | DAC code, also used for the data packet |

## Verification
The bench builds the block with its defaults: a 12-bit code and K_MAX = 15, which gives a 27-bit accumulator. With k = 0 each bit is worth a whole code step, so both saturation rails can be reached within a few thousand cycles. The k = 15 end of the range is tested at its exact threshold of 32768 ones. A behavioural model with a wide integer accumulator follows every cycle, including mixed bitstream patterns at an intermediate k.

// File: rtl/offset_trim_pkg.sv
package offset_trim_pkg;
  // Strobes from control to accumulator datapath
  typedef struct packed {
    logic load;   // follow configured value
    logic up;     // add one step
    logic down;   // subtract one step
  } trimCmd_t;
endpackage

// File: rtl/trim_ctrl.sv
module trim_ctrl
  import offset_trim_pkg::*;
(
  input  logic     useInteg,
  input  logic     enable,
  input  logic     bitValid,
  input  logic     bitIn,
  output trimCmd_t cmd
);
  logic accept;

  always_comb begin
    accept   = useInteg && enable && bitValid;
    cmd.load = !useInteg;
    cmd.up   = accept && bitIn;
    cmd.down = accept && !bitIn;
  end
endmodule

// File: rtl/trim_acc.sv
module trim_acc
  import offset_trim_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int K_MAX  = 15,
  parameter int TC_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  trimCmd_t          cmd,
  input  logic [CODE_W-1:0] regCode,
  input  logic [TC_W-1:0]   tcSel,
  output logic [CODE_W-1:0] accCode
);
  localparam int ACC_W = CODE_W + K_MAX;
  localparam logic [ACC_W-1:0] ACC_TOP = '1;
  localparam logic [ACC_W-1:0] ACC_MID = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] ONE     = {{(ACC_W-1){1'b0}}, 1'b1};

  logic [ACC_W-1:0] acc, accNext, stepVal, headroom;
  int unsigned      kEff;

  always_comb begin
    kEff     = (int'(tcSel) > K_MAX) ? K_MAX : int'(tcSel);
    stepVal  = ONE << (K_MAX - kEff);
    headroom = ACC_TOP - acc;
    accNext  = acc;
    if (cmd.load)
      accNext = {regCode, {K_MAX{1'b0}}};
    else if (cmd.up)
      accNext = (headroom < stepVal) ? ACC_TOP : acc + stepVal;
    else if (cmd.down)
      accNext = (acc < stepVal) ? '0 : acc - stepVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) acc <= ACC_MID;
    else       acc <= accNext;
  end

  assign accCode = acc[ACC_W-1 -: CODE_W];
endmodule

// File: rtl/offset_trim_loop.sv
module offset_trim_loop
  import offset_trim_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int K_MAX  = 15,
  parameter int TC_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValid,
  input  logic              bitIn,
  input  logic              useInteg,
  input  logic [CODE_W-1:0] regCode,
  input  logic [TC_W-1:0]   tcSel,
  input  logic              enable,
  output logic [CODE_W-1:0] dacCode
);
  trimCmd_t          cmd;
  logic [CODE_W-1:0] accCode;

  trim_ctrl u_ctrl (
    .useInteg(useInteg), .enable(enable), .bitValid(bitValid),
    .bitIn(bitIn), .cmd(cmd)
  );

  trim_acc #(.CODE_W(CODE_W), .K_MAX(K_MAX), .TC_W(TC_W)) u_acc (
    .clk(clk), .rstN(rstN), .cmd(cmd), .regCode(regCode),
    .tcSel(tcSel), .accCode(accCode)
  );

  assign dacCode = useInteg ? accCode : regCode;
endmodule

// File: rtl/offset_trim_chk.sv
module offset_trim_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              bitValid,
  input logic              bitIn,
  input logic              useInteg,
  input logic [CODE_W-1:0] regCode,
  input logic              enable,
  input logic [CODE_W-1:0] dacCode
);
  localparam logic [CODE_W-1:0] FULL = '1;

  // R3
  preload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (useInteg && $past(rstN) && !$past(useInteg)) |-> (dacCode == $past(regCode)));

  // R5
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (useInteg && $past(useInteg) && $past(rstN) && !$past(bitValid)) |-> $stable(dacCode));

  // R6
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (useInteg && $past(useInteg) && $past(rstN) && !$past(enable)) |-> $stable(dacCode));

  // R4
  up_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (useInteg && $past(useInteg) && $past(rstN) && $past(enable && bitValid && bitIn))
      |-> (dacCode >= $past(dacCode)));

  // R7
  top_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (useInteg && $past(useInteg) && $past(rstN) && $past(dacCode) == FULL &&
     $past(enable && bitValid && bitIn)) |-> (dacCode == FULL));

  // R8
  bottom_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (useInteg && $past(useInteg) && $past(rstN) && $past(dacCode) == '0 &&
     $past(enable && bitValid && !bitIn)) |-> (dacCode == '0));
endmodule

bind offset_trim_loop offset_trim_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
  .useInteg(useInteg), .regCode(regCode), .enable(enable), .dacCode(dacCode)
);

// File: tb/tb_offset_trim_loop.sv
`timescale 1ns/1ps
module tb_offset_trim_loop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitValid = 1'b0, bitIn = 1'b0, useInteg = 1'b1, enable = 1'b0;
  logic [11:0] regCode = '0;
  logic [3:0]  tcSel = '0;
  logic [11:0] dacCode;

  int checks = 0, fails = 0;
  bit done = 0;
  longint accM = 64'sd1 << 26;
  localparam longint MAXV = (64'sd1 << 27) - 1;

  always #4 clk = ~clk;

  offset_trim_loop dut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .useInteg(useInteg), .regCode(regCode), .tcSel(tcSel),
    .enable(enable), .dacCode(dacCode)
  );

  // behavioural reference: wide integer accumulator
  always @(posedge clk) begin
    longint st;
    if (!rstN) accM = 64'sd1 << 26;
    else if (!useInteg) accM = longint'(regCode) * 32768;
    else if (enable && bitValid) begin
      st = 64'sd1 << (15 - int'(tcSel));
      if (bitIn) accM = (accM + st > MAXV) ? MAXV : accM + st;
      else       accM = (accM < st) ? 0 : accM - st;
    end
  end

  function automatic logic [11:0] expCode();
    return useInteg ? 12'(accM / 32768) : regCode;
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus and compare against the model
  task automatic cyc(string tag, logic v, logic b, logic u, logic e,
                     logic [3:0] k, logic [11:0] r);
    @(negedge clk);
    bitValid = v; bitIn = b; useInteg = u; enable = e; tcSel = k; regCode = r;
    #1 check(tag, dacCode, expCode());
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 check("R1 in reset", dacCode, 12'h800);
    rstN = 1'b1;
    for (int i = 0; i < 3; i++) cyc("R1 after reset", 0, 1, 1, 1, 0, 12'h555);
    check("R1 midscale", dacCode, 12'h800);

    // register source
    cyc("R2 reg", 1, 1, 0, 1, 0, 12'h123);
    check("R2 reg value", dacCode, 12'h123);
    cyc("R2 reg change", 1, 0, 0, 0, 7, 12'hABC);
    check("R2 same-cycle", dacCode, 12'hABC);
    cyc("R3 reg", 1, 1, 0, 1, 0, 12'h3C0);
    cyc("R3 switch", 0, 0, 1, 1, 0, 12'h000);
    check("R3 preload", dacCode, 12'h3C0);

    // k = 0 stepping
    for (int i = 0; i < 10; i++) cyc("R4 ones", 1, 1, 1, 1, 0, 12'h000);
    cyc("R4 idle", 0, 0, 1, 1, 0, 12'h000);
    check("R9 k0 ten ones", dacCode, 12'h3CA);
    for (int i = 0; i < 4; i++) cyc("R4 zeros", 1, 0, 1, 1, 0, 12'h000);
    cyc("R4 idle", 0, 0, 1, 1, 0, 12'h000);
    check("R4 four zeros", dacCode, 12'h3C6);

    for (int i = 0; i < 20; i++) cyc("R5 no valid", 0, 1, 1, 1, 0, 12'hFFF);
    check("R5 unchanged", dacCode, 12'h3C6);
    for (int i = 0; i < 20; i++) cyc("R6 disabled", 1, 1, 1, 0, 0, 12'hFFF);
    check("R6 unchanged", dacCode, 12'h3C6);

    for (int i = 0; i < 4000; i++) cyc("R7 ramp", 1, 1, 1, 1, 0, 12'h000);
    check("R7 top rail", dacCode, 12'hFFF);
    for (int i = 0; i < 5000; i++) cyc("R8 ramp", 1, 0, 1, 1, 0, 12'h000);
    check("R8 bottom rail", dacCode, 12'h000);

    // mixed pattern at intermediate k
    for (int i = 0; i < 3000; i++) cyc("R4 mixed", (i % 5) != 4, (i % 3) != 2, 1, 1, 4, 12'h000);

    // slow time constant threshold
    cyc("R3 reload", 0, 0, 0, 1, 15, 12'h800);
    for (int i = 0; i < 32767; i++) cyc("R9 k15", 1, 1, 1, 1, 15, 12'h000);
    cyc("R9 k15 idle", 0, 0, 1, 1, 15, 12'h000);
    check("R9 k15 below step", dacCode, 12'h800);
    cyc("R9 k15 last", 1, 1, 1, 1, 15, 12'h000);
    cyc("R9 k15 idle", 0, 0, 1, 1, 15, 12'h000);
    check("R9 k15 step", dacCode, 12'h801);
    finishRun();
  end
endmodule